// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches a bank of general-purpose input pins (28 by default) and turns their transitions into interrupt requests. Every pin is brought into the clock domain through a two-flop synchronizer. It is then compared with its previous synchronized sample to find rising and falling edges. Two enable masks choose which edge directions count for each pin. A qualifying edge latches a sticky per-pin status bit, which stays set until software writes a one to it.

The lower eleven status bits each drive their own interrupt line. The upper seventeen are merged into one shared line, and software reads the status register to find which pin fired. A per-pin wake mask selects which latched events raise a single wake request. A small arming state machine holds edge detection off after reset until the synchronizer history is valid. Its two states are PRIME, which counts SYNC_STAGES+1 clocks, and LIVE. The transitions are PRIME to PRIME while the count runs, PRIME to LIVE when it expires, and LIVE to LIVE for as long as reset is not applied. Reset returns the machine to PRIME.

A flat register port gives access to everything. Writes take effect on the clock edge on which `reg_we` is high. Reads are combinational from `reg_addr`.

Top module: `gpio_edge_irq`

## Requirements
- R1: With bit n of the rising mask (address 0) set, a 0-to-1 change on `pin_in[n]` sets status bit n. The bit is visible at the outputs after the third rising clock edge following the pin change, and not after the second.
- R2: With bit n of the falling mask (address 1) set, a 1-to-0 change on `pin_in[n]` sets status bit n. A direction whose mask bit is clear sets nothing.
- R3: With both mask bits of a pin set, either direction of change sets that pin's status bit.
- R4: Writing the status register (address 2) clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R5: `irq_direct[k]` equals status bit k for k = 0 to 10.
- R6: `irq_shared` is high exactly while any of status bits 11 to 27 is set, and stays high until the last of them is cleared.
- R7: After reset, both edge masks, the wake mask and the status register read 0 and all interrupt and wake outputs are low.
- R8: `wake_req` is the OR over all pins of status bit AND wake-mask bit (wake mask at address 3).
- R9: When a new enabled edge and a write of 1 to the same status bit land on the same clock edge, the bit ends up set. Other bits in the same write are still cleared.
- R10: Pin levels present at reset create no status bits, even if edge masks are enabled in the first cycle after reset. Detection starts only once the arming machine reaches LIVE.
- R11: Register bits 31 to 28 read as 0 and ignore writes. Addresses 4 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 28 | Asynchronous pin levels |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_direct | output | 11 | Per-pin interrupts for pins 0 to 10 |
| irq_shared | output | 1 | Combined interrupt for pins 11 to 27 |
| wake_req | output | 1 | Wake request |

## Verification
A status bit can be set by a detected edge and cleared by a software write on the same clock edge. The bench drives a pin transition and then times a write-one-to-clear so that the write is sampled on exactly the edge where the synchronized transition reaches the status register. That write covers both the colliding bit and a second bit that is already latched. Afterwards the colliding bit must read as set and the other bit as cleared. A second case fits the same pattern: enabling the masks in the very first cycle after reset overlaps the arming window, and is judged by the status register staying at zero.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Register word indices; software depends on these positions.
    localparam int REG_RISE_IDX = 0;
    localparam int REG_FALL_IDX = 1;
    localparam int REG_STAT_IDX = 2;
    localparam int REG_WAKE_IDX = 3;

    typedef enum logic [0:0] {
        ARM_PRIME = 1'b0,
        ARM_LIVE  = 1'b1
    } arm_state_e;

    typedef enum logic [2:0] {
        SEL_RISE,
        SEL_FALL,
        SEL_STAT,
        SEL_WAKE,
        SEL_NONE
    } reg_sel_e;

endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 28,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= '0;
        else        chain_q[0] <= raw_in;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_q[g-1];
        end
    end

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_arm_fsm.sv
module gpio_arm_fsm
    import gpio_irq_pkg::*;
#(
    parameter int SETTLE = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic armed
);

    localparam int CNT_W = (SETTLE < 2) ? 1 : $clog2(SETTLE);

    arm_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARM_PRIME;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ARM_PRIME: begin
                if (cnt_q == CNT_W'(SETTLE - 1)) state_d = ARM_LIVE;
                else                             cnt_d   = cnt_q + 1'b1;
            end
            ARM_LIVE:  state_d = ARM_LIVE;
            default:   state_d = ARM_PRIME;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ARM_LIVE: armed = 1'b1;
            default:  armed = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic             armed,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    output logic [WIDTH-1:0] edge_hit
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] went_up, went_down;

    // History follows the synchronizer even while disarmed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    always_comb begin
        went_up   = level & ~prev_q;
        went_down = ~level & prev_q;
        edge_hit  = armed ? ((went_up & rise_en) | (went_down & fall_en)) : '0;
    end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS   = 28,
    parameter int NUM_DIRECT = 11,
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_PINS-1:0]   edge_hit,
    output logic [NUM_PINS-1:0]   rise_en,
    output logic [NUM_PINS-1:0]   fall_en,
    output logic [NUM_PINS-1:0]   status,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_shared,
    output logic                  wake_req
);

    localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(REG_RISE_IDX);
    localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(REG_FALL_IDX);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT_IDX);
    localparam logic [ADDR_W-1:0] A_WAKE = ADDR_W'(REG_WAKE_IDX);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] wr_bits;
    logic [NUM_PINS-1:0] rise_q, fall_q, wake_q, stat_q;
    logic [NUM_PINS-1:0] clr_mask;
    logic                unused_wdata_hi;

    assign wr_bits         = reg_wdata[NUM_PINS-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_PINS];

    always_comb begin
        unique case (reg_addr)
            A_RISE:  sel = SEL_RISE;
            A_FALL:  sel = SEL_FALL;
            A_STAT:  sel = SEL_STAT;
            A_WAKE:  sel = SEL_WAKE;
            default: sel = SEL_NONE;
        endcase
    end

    assign clr_mask = (reg_we && sel == SEL_STAT) ? wr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_q <= '0;
            fall_q <= '0;
            wake_q <= '0;
        end else if (reg_we) begin
            unique case (sel)
                SEL_RISE: rise_q <= wr_bits;
                SEL_FALL: fall_q <= wr_bits;
                SEL_WAKE: wake_q <= wr_bits;
                default:  ;
            endcase
        end
    end

    // Sticky status: a new edge outranks a clear on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_mask) | edge_hit;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_RISE: reg_rdata[NUM_PINS-1:0] = rise_q;
            SEL_FALL: reg_rdata[NUM_PINS-1:0] = fall_q;
            SEL_STAT: reg_rdata[NUM_PINS-1:0] = stat_q;
            SEL_WAKE: reg_rdata[NUM_PINS-1:0] = wake_q;
            default:  reg_rdata = '0;
        endcase
    end

    assign rise_en    = rise_q;
    assign fall_en    = fall_q;
    assign status     = stat_q;
    assign irq_direct = stat_q[NUM_DIRECT-1:0];
    assign wake_req   = |(stat_q & wake_q);

    if (NUM_PINS > NUM_DIRECT) begin : g_shared
        assign irq_shared = |stat_q[NUM_PINS-1:NUM_DIRECT];
    end else begin : g_no_shared
        assign irq_shared = 1'b0;
    end

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NUM_PINS    = 28,
    parameter int NUM_DIRECT  = 11,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 3,
    parameter int DATA_W      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_in,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic [NUM_DIRECT-1:0] irq_direct,
    output logic                  irq_shared,
    output logic                  wake_req
);

    localparam int SETTLE = SYNC_STAGES + 1;

    logic [NUM_PINS-1:0] level_w;
    logic [NUM_PINS-1:0] edge_w;
    logic [NUM_PINS-1:0] rise_en_w, fall_en_w, status_w;
    logic                armed_w;

    gpio_pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (level_w)
    );

    gpio_arm_fsm #(.SETTLE(SETTLE)) u_arm (
        .clk   (clk),
        .rst_n (rst_n),
        .armed (armed_w)
    );

    gpio_edge_detect #(.WIDTH(NUM_PINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level_w),
        .armed    (armed_w),
        .rise_en  (rise_en_w),
        .fall_en  (fall_en_w),
        .edge_hit (edge_w)
    );

    gpio_irq_regs #(
        .NUM_PINS   (NUM_PINS),
        .NUM_DIRECT (NUM_DIRECT),
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .edge_hit   (edge_w),
        .rise_en    (rise_en_w),
        .fall_en    (fall_en_w),
        .status     (status_w),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared),
        .wake_req   (wake_req)
    );

endmodule

// File: rtl/gpio_irq_checks.sv
module gpio_irq_checks
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PINS = 28,
    parameter int ADDR_W   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [NUM_PINS-1:0] wdata_lo,
    input logic [NUM_PINS-1:0] status,
    input logic [NUM_PINS-1:0] edge_hit,
    input logic [NUM_PINS-1:0] rise_en,
    input logic [NUM_PINS-1:0] fall_en,
    input logic                armed,
    input logic                irq_shared
);

    logic stat_wr;
    assign stat_wr = reg_we && (reg_addr == ADDR_W'(REG_STAT_IDX));

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status & $past(wdata_lo) & ~$past(edge_hit)) == '0));

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_hit) |=> ((status & $past(edge_hit)) == $past(edge_hit)));

    p_need_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(status) |->
            ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0));

    p_prime_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (edge_hit == '0));

    p_shared_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_shared && !stat_wr) |=> irq_shared);

endmodule

bind gpio_edge_irq gpio_irq_checks #(
    .NUM_PINS (NUM_PINS),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .wdata_lo   (reg_wdata[NUM_PINS-1:0]),
    .status     (status_w),
    .edge_hit   (edge_w),
    .rise_en    (rise_en_w),
    .fall_en    (fall_en_w),
    .armed      (armed_w),
    .irq_shared (irq_shared)
);

// File: tb/sim_gpio_edge_irq.sv
module sim_gpio_edge_irq;

    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_RISE = 3'd0;
    localparam logic [2:0] A_FALL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_WAKE = 3'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [27:0] pin_in = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [10:0] irq_direct;
    logic        irq_shared;
    logic        wake_req;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_edge_irq u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_direct (irq_direct),
        .irq_shared (irq_shared),
        .wake_req   (wake_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cleanup();
        wr(A_RISE, '0); wr(A_FALL, '0); wr(A_WAKE, '0);
        pin_in = '0; cycles(4);
        wr(A_STAT, 32'hFFFF_FFFF);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        pin_in = 28'h010_0020;          // pins 5 and 20 high through reset
        rst_n = 1'b0; cycles(3);
        rst_n = 1'b1;
        rd(A_RISE, v); chk("R7 rise mask after reset", v, 0);
        rd(A_FALL, v); chk("R7 fall mask after reset", v, 0);
        rd(A_WAKE, v); chk("R7 wake mask after reset", v, 0);
        rd(A_STAT, v); chk("R7 status after reset", v, 0);
        chk("R7 outputs after reset", {19'd0, irq_direct, irq_shared, wake_req}, 0);
        wr(A_RISE, 32'h0FFF_FFFF);      // enabled inside arming window
        cycles(8);
        rd(A_STAT, v); chk("R10 no status from reset levels", v, 0);
        cleanup();
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(A_RISE, 32'h8);
        pin_in[3] = 1'b1;
        cycles(2); chk("R1 not yet after two edges", {31'd0, irq_direct[3]}, 0);
        cycles(1); chk("R1 R5 direct line after third edge", {21'd0, irq_direct}, 32'h8);
        wr(A_STAT, 32'h8);
        pin_in[3] = 1'b0; cycles(5);
        rd(A_STAT, v); chk("R2 falling ignored when only rise set", v, 0);
        cleanup();
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(A_FALL, 32'h80);
        pin_in[7] = 1'b1; cycles(5);
        rd(A_STAT, v); chk("R2 rising ignored when only fall set", v, 0);
        pin_in[7] = 1'b0; cycles(3);
        rd(A_STAT, v); chk("R2 falling edge latched", v, 32'h80);
        chk("R5 direct line 7", {21'd0, irq_direct}, 32'h80);
        cleanup();
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(A_RISE, 32'h4000); wr(A_FALL, 32'h4000);
        pin_in[14] = 1'b1; cycles(3);
        rd(A_STAT, v); chk("R3 rise with both enabled", v, 32'h4000);
        chk("R6 shared line up", {31'd0, irq_shared}, 1);
        chk("R5 no direct line for pin 14", {21'd0, irq_direct}, 0);
        wr(A_STAT, 32'h4000);
        pin_in[14] = 1'b0; cycles(3);
        rd(A_STAT, v); chk("R3 fall with both enabled", v, 32'h4000);
        cleanup();
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(A_RISE, 32'h0010_4008);
        pin_in[3] = 1'b1; pin_in[14] = 1'b1; pin_in[20] = 1'b1; cycles(4);
        wr(A_STAT, 32'h0);
        rd(A_STAT, v); chk("R4 zero write keeps bits", v, 32'h0010_4008);
        wr(A_STAT, 32'h4000);
        rd(A_STAT, v); chk("R4 clears only written bit", v, 32'h0010_0008);
        chk("R6 shared holds on remaining bit", {31'd0, irq_shared}, 1);
        wr(A_STAT, 32'h0010_0000);
        chk("R6 shared drops after last clear", {31'd0, irq_shared}, 0);
        chk("R5 pin 3 line still set", {21'd0, irq_direct}, 32'h8);
        cleanup();
    endtask

    task automatic t_wake();
        wr(A_WAKE, 32'h0010_0000);
        wr(A_RISE, 32'h0010_0008);
        pin_in[3] = 1'b1; cycles(4);
        chk("R8 unmasked bit gives no wake", {31'd0, wake_req}, 0);
        pin_in[20] = 1'b1; cycles(4);
        chk("R8 masked-in bit gives wake", {31'd0, wake_req}, 1);
        wr(A_STAT, 32'h0010_0000);
        chk("R8 wake drops with status", {31'd0, wake_req}, 0);
        cleanup();
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(A_RISE, 32'h210);
        pin_in[4] = 1'b1; cycles(4);    // bit 4 latched
        pin_in[9] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_addr = A_STAT; reg_wdata = 32'h210; reg_we = 1'b1;
        @(posedge clk); @(negedge clk);  // edge of pin 9 lands here
        reg_we = 1'b0;
        rd(A_STAT, v); chk("R9 set wins, other bit cleared", v, 32'h200);
        cleanup();
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(A_WAKE, 32'hFFFF_FFFF);
        rd(A_WAKE, v); chk("R11 upper bits read zero", v, 32'h0FFF_FFFF);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R11 unmapped address reads zero", v, 0);
        rd(A_RISE, v); chk("R11 unmapped write leaves rise mask", v, 0);
        cleanup();
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_w1c();
        t_wake();
        t_collide();
        t_map();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule